// File: doc/BRIEF.md
# Pipeline Control Word Shifter

This block produces and carries the control bits of a five-stage in-order pipeline. A small decoder looks at the opcode and function fields of the instruction that sits in the decode stage and builds its full control word in that same cycle. The word is then clocked through three stage registers: decode-to-execute, execute-to-memory and memory-to-writeback. Each stage keeps only the bits that it or a later stage still needs. As a result, every stage is driven only by the instruction that currently occupies it.

The decoder knows four instruction classes: register-register arithmetic, load word, store word and branch-if-equal. Any other encoding decodes to the all-zero bubble word. A stall request keeps the fetch side where it is and puts a zero word into execute. The older instructions ahead of it keep moving. A flush request also puts a zero word into execute, and it wins over both a stall and normal issue. A three-state issue controller records what was placed into execute on each clock. Its states are ISS_RUN (a decoded word was issued), ISS_STALL (a bubble was placed because of a stall) and ISS_FLUSH (a bubble was placed because of a flush). On every clock it moves to ISS_FLUSH when flush is high. Otherwise it moves to ISS_STALL when stall is high, and otherwise to ISS_RUN. Reset puts it in ISS_RUN.

Top module: `pctl_shifter`

## Requirements
- R1: A synchronous active-high reset clears every stage output to zero on the next clock edge.
- R2: Opcode 0x00 with function 0x20, 0x22, 0x24 or 0x25 decodes to ALU op 1 (add), 2 (subtract), 3 (and) or 4 (or) respectively, with register-destination select 1 and register write 1; every other bit is 0.
- R3: Opcode 0x23 (load) decodes to extend 1, ALU source 1, ALU op 1, memory-to-register 1 and register write 1; every other bit is 0.
- R4: Opcode 0x2B (store) decodes to extend 1, ALU source 1, ALU op 1 and memory write 1; every other bit is 0.
- R5: Opcode 0x04 (branch-if-equal) decodes to ALU op 2 and branch 1; every other bit is 0.
- R6: Any other opcode, and opcode 0x00 with any other function value, decodes to the all-zero word.
- R7: The execute outputs show the decoded word of the instruction presented in cycle t during cycle t+1.
- R8: The memory outputs (memory write, branch) show that instruction's bits during cycle t+2, unchanged.
- R9: The writeback outputs (memory-to-register, register write) show that instruction's bits during cycle t+3, unchanged.
- R10: When stall is high and flush is low, fetch_hold is high in the same cycle and the execute outputs are all zero in the next cycle, while older words keep advancing.
- R11: When flush is high, the execute outputs are all zero in the next cycle whatever stall and the opcode are, and fetch_hold is low.
- R12: A bubble word never asserts memory write or register write in any later stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_opcode | input | 6 | Opcode field of the instruction in decode |
| dec_funct | input | 6 | Function field of the instruction in decode |
| stall_req | input | 1 | Hold fetch and issue a bubble |
| flush_req | input | 1 | Issue a bubble, highest priority |
| fetch_hold | output | 1 | Freeze PC and fetch register this cycle |
| ex_ext_op | output | 1 | Execute: sign-extend immediate |
| ex_alu_src | output | 1 | Execute: ALU second operand is immediate |
| ex_alu_op | output | 3 | Execute: ALU function |
| ex_reg_dst | output | 1 | Execute: destination from rd field |
| mem_wr | output | 1 | Memory: write data memory |
| mem_branch | output | 1 | Memory: branch-if-equal |
| wb_mem_to_reg | output | 1 | Writeback: select memory data |
| wb_reg_wr | output | 1 | Writeback: write register file |

## Verification
The bench models the three stage registers itself, so any corruption inside the block appears at the ports within three cycles. A wrong decode or a missed bubble shows on the execute bus one cycle after the instruction is presented. A bit dropped or changed in a hand-off shows on the memory bus one cycle later or on the writeback bus two cycles later. Random streams with stalls and flushes mixed in, plus directed back-to-back stalls, exercise every issue-controller transition.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    parameter int OPC_W = 6;
    parameter int FN_W  = 6;
    parameter int ALU_W = 3;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;

    typedef enum logic [ALU_W-1:0] {
        ALU_NONE = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    ext_op;
        logic    alu_src;
        alu_op_e alu_op;
        logic    reg_dst;
    } ex_ctl_t;

    typedef struct packed {
        logic mem_wr;
        logic branch;
    } mem_ctl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_wr;
    } wb_ctl_t;

    typedef struct packed {
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } idex_word_t;

    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } exmem_word_t;

    typedef enum logic [1:0] {
        ISS_RUN   = 2'd0,
        ISS_STALL = 2'd1,
        ISS_FLUSH = 2'd2
    } iss_state_e;

endpackage

// File: rtl/pctl_decoder.sv
module pctl_decoder
    import pctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output idex_word_t       word
);

    always_comb begin
        word = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                word.ex.reg_dst = 1'b1;
                word.wb.reg_wr  = 1'b1;
                unique case (funct)
                    FN_ADD:  word.ex.alu_op = ALU_ADD;
                    FN_SUB:  word.ex.alu_op = ALU_SUB;
                    FN_AND:  word.ex.alu_op = ALU_AND;
                    FN_OR:   word.ex.alu_op = ALU_OR;
                    default: word = '0;
                endcase
            end
            OPC_LOAD: begin
                word.ex.ext_op     = 1'b1;
                word.ex.alu_src    = 1'b1;
                word.ex.alu_op     = ALU_ADD;
                word.wb.mem_to_reg = 1'b1;
                word.wb.reg_wr     = 1'b1;
            end
            OPC_STORE: begin
                word.ex.ext_op  = 1'b1;
                word.ex.alu_src = 1'b1;
                word.ex.alu_op  = ALU_ADD;
                word.mem.mem_wr = 1'b1;
            end
            OPC_BEQ: begin
                word.ex.alu_op  = ALU_SUB;
                word.mem.branch = 1'b1;
            end
            default: word = '0;
        endcase
    end

    // R6 / R12: a decoded word has at most one architectural side effect
    always_comb begin
        assert_single_effect_R6: assert ($onehot0({word.mem.mem_wr, word.wb.reg_wr, word.mem.branch}));
    end

endmodule

// File: rtl/pctl_issue_fsm.sv
module pctl_issue_fsm
    import pctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stall_req,
    input  logic       flush_req,
    output iss_state_e state,
    output logic       inject_bubble,
    output logic       fetch_hold
);

    iss_state_e state_nx;

    always_comb begin
        if (flush_req) begin
            state_nx = ISS_FLUSH;
        end else if (stall_req) begin
            state_nx = ISS_STALL;
        end else begin
            state_nx = ISS_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ISS_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        inject_bubble = 1'b0;
        fetch_hold    = 1'b0;
        unique case (state_nx)
            ISS_RUN: begin
                inject_bubble = 1'b0;
                fetch_hold    = 1'b0;
            end
            ISS_STALL: begin
                inject_bubble = 1'b1;
                fetch_hold    = 1'b1;
            end
            ISS_FLUSH: begin
                inject_bubble = 1'b1;
                fetch_hold    = 1'b0;
            end
            default: begin
                inject_bubble = 1'b1;
                fetch_hold    = 1'b0;
            end
        endcase
    end

    assert_flush_wins_R11: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> (state == ISS_FLUSH));

endmodule

// File: rtl/pctl_stage_reg.sv
module pctl_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/pctl_shifter.sv
module pctl_shifter
    import pctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] dec_opcode,
    input  logic [FN_W-1:0]  dec_funct,
    input  logic             stall_req,
    input  logic             flush_req,
    output logic             fetch_hold,
    output logic             ex_ext_op,
    output logic             ex_alu_src,
    output logic [ALU_W-1:0] ex_alu_op,
    output logic             ex_reg_dst,
    output logic             mem_wr,
    output logic             mem_branch,
    output logic             wb_mem_to_reg,
    output logic             wb_reg_wr
);

    localparam int IDEX_W  = $bits(idex_word_t);
    localparam int EXMEM_W = $bits(exmem_word_t);
    localparam int MEMWB_W = $bits(wb_ctl_t);

    idex_word_t  dec_word;
    idex_word_t  idex_d;
    idex_word_t  idex_q;
    exmem_word_t exmem_d;
    exmem_word_t exmem_q;
    wb_ctl_t     memwb_q;
    iss_state_e  iss_state;
    logic        inject_bubble;

    pctl_decoder u_dec (
        .opcode (dec_opcode),
        .funct  (dec_funct),
        .word   (dec_word)
    );

    pctl_issue_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .stall_req     (stall_req),
        .flush_req     (flush_req),
        .state         (iss_state),
        .inject_bubble (inject_bubble),
        .fetch_hold    (fetch_hold)
    );

    assign idex_d = inject_bubble ? idex_word_t'('0) : dec_word;

    pctl_stage_reg #(.W(IDEX_W)) u_idex (
        .clk (clk),
        .rst (rst),
        .d   (idex_d),
        .q   (idex_q)
    );

    // execute bits are consumed here; memory and writeback bits move on
    assign exmem_d.mem = idex_q.mem;
    assign exmem_d.wb  = idex_q.wb;

    pctl_stage_reg #(.W(EXMEM_W)) u_exmem (
        .clk (clk),
        .rst (rst),
        .d   (exmem_d),
        .q   (exmem_q)
    );

    pctl_stage_reg #(.W(MEMWB_W)) u_memwb (
        .clk (clk),
        .rst (rst),
        .d   (exmem_q.wb),
        .q   (memwb_q)
    );

    assign ex_ext_op     = idex_q.ex.ext_op;
    assign ex_alu_src    = idex_q.ex.alu_src;
    assign ex_alu_op     = idex_q.ex.alu_op;
    assign ex_reg_dst    = idex_q.ex.reg_dst;
    assign mem_wr        = exmem_q.mem.mem_wr;
    assign mem_branch    = exmem_q.mem.branch;
    assign wb_mem_to_reg = memwb_q.mem_to_reg;
    assign wb_reg_wr     = memwb_q.reg_wr;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (idex_q == '0 && exmem_q == '0 && memwb_q == '0));

    assert_issue_decoded_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && !flush_req) |=> (idex_q == $past(dec_word)));

    assert_mem_follows_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (exmem_q.mem == $past(idex_q.mem) && exmem_q.wb == $past(idex_q.wb)));

    assert_wb_follows_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (memwb_q == $past(exmem_q.wb)));

    assert_bubble_state_R10: assert property (@(posedge clk) disable iff (rst)
        (iss_state != ISS_RUN) |-> (idex_q == '0));

    assert_bubble_no_write_R12: assert property (@(posedge clk) disable iff (rst)
        (iss_state != ISS_RUN) |=> (!mem_wr && !exmem_q.wb.reg_wr));

endmodule

// File: tb/pctl_shifter_test.sv
`timescale 1ns/1ps
module pctl_shifter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] dec_opcode = 6'h3F;
    logic [5:0] dec_funct = 6'h00;
    logic       stall_req = 1'b0;
    logic       flush_req = 1'b0;
    logic       fetch_hold;
    logic       ex_ext_op, ex_alu_src, ex_reg_dst;
    logic [2:0] ex_alu_op;
    logic       mem_wr, mem_branch, wb_mem_to_reg, wb_reg_wr;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // model words: {ext, src, aluop[2:0], rdst, mwr, br, m2r, rwr}
    logic [9:0] m_ex = '0, m_mem = '0, m_wb = '0;
    string      t_ex = "R1";

    always #4 clk = ~clk;

    pctl_shifter uut (
        .clk (clk), .rst (rst),
        .dec_opcode (dec_opcode), .dec_funct (dec_funct),
        .stall_req (stall_req), .flush_req (flush_req),
        .fetch_hold (fetch_hold),
        .ex_ext_op (ex_ext_op), .ex_alu_src (ex_alu_src),
        .ex_alu_op (ex_alu_op), .ex_reg_dst (ex_reg_dst),
        .mem_wr (mem_wr), .mem_branch (mem_branch),
        .wb_mem_to_reg (wb_mem_to_reg), .wb_reg_wr (wb_reg_wr)
    );

    function automatic logic [9:0] ref_word(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'h00: case (fn)
                6'h20: return 10'b0_0_001_1_00_01;
                6'h22: return 10'b0_0_010_1_00_01;
                6'h24: return 10'b0_0_011_1_00_01;
                6'h25: return 10'b0_0_100_1_00_01;
                default: return 10'b0;
            endcase
            6'h23: return 10'b1_1_001_0_00_11;
            6'h2B: return 10'b1_1_001_0_10_00;
            6'h04: return 10'b0_0_010_0_01_00;
            default: return 10'b0;
        endcase
    endfunction

    function automatic string ref_tag(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25)) return "R2";
        if (op == 6'h23) return "R3";
        if (op == 6'h2B) return "R4";
        if (op == 6'h04) return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive one cycle of inputs, advance the model, check all stages
    task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic st, input logic fl);
        dec_opcode = op;
        dec_funct  = fn;
        stall_req  = st;
        flush_req  = fl;
        #1;
        if (fl) check("R11 fetch_hold", {9'b0, fetch_hold}, 10'b0);
        else    check("R10 fetch_hold", {9'b0, fetch_hold}, {9'b0, st});
        @(posedge clk);
        m_wb  = m_mem;
        m_mem = m_ex;
        if (fl) begin
            m_ex = '0; t_ex = "R11";
        end else if (st) begin
            m_ex = '0; t_ex = "R10";
        end else begin
            m_ex = ref_word(op, fn); t_ex = {ref_tag(op, fn), "/R7"};
        end
        @(negedge clk);
        check(t_ex, {ex_ext_op, ex_alu_src, ex_alu_op, ex_reg_dst, 4'b0}, {m_ex[9:4], 4'b0});
        check("R8", {6'b0, mem_wr, mem_branch, 2'b0}, {6'b0, m_mem[3:2], 2'b0});
        check("R9", {8'b0, wb_mem_to_reg, wb_reg_wr}, {8'b0, m_wb[1:0]});
        if (m_mem[3] == 1'b0) check("R12 mem", {9'b0, mem_wr}, 10'b0);
        if (m_wb[0] == 1'b0)  check("R12 wb", {9'b0, wb_reg_wr}, 10'b0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1357);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {ex_ext_op, ex_alu_src, ex_alu_op, ex_reg_dst, mem_wr, mem_branch,
                     wb_mem_to_reg, wb_reg_wr}, 10'b0);
        rst = 1'b0;

        // directed: each class in turn
        step(6'h00, 6'h20, 0, 0);
        step(6'h00, 6'h22, 0, 0);
        step(6'h00, 6'h24, 0, 0);
        step(6'h00, 6'h25, 0, 0);
        step(6'h23, 6'h11, 0, 0);
        step(6'h2B, 6'h00, 0, 0);
        step(6'h04, 6'h3F, 0, 0);
        step(6'h00, 6'h21, 0, 0);
        step(6'h3F, 6'h20, 0, 0);
        // back-to-back stalls holding a store, then issue it
        step(6'h2B, 6'h00, 1, 0);
        step(6'h2B, 6'h00, 1, 0);
        step(6'h2B, 6'h00, 0, 0);
        // flush over stall and over a load
        step(6'h23, 6'h00, 1, 1);
        step(6'h23, 6'h00, 0, 1);
        step(6'h00, 6'h20, 0, 0);
        step(6'h00, 6'h20, 0, 0);
        step(6'h00, 6'h20, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op, fn;
            int pick;
            pick = $urandom_range(0, 5);
            fn = 6'($urandom);
            case (pick)
                0: begin op = 6'h00; fn = 6'h20 + 6'($urandom_range(0, 2) * 2); end
                1: begin op = 6'h00; fn = ($urandom_range(0, 1) != 0) ? 6'h25 : fn; end
                2: op = 6'h23;
                3: op = 6'h2B;
                4: op = 6'h04;
                default: op = 6'($urandom);
            endcase
            step(op, fn, ($urandom_range(0, 99) < 20), ($urandom_range(0, 99) < 8));
        end

        // R1: reset mid-stream clears every stage
        dec_opcode = 6'h23; stall_req = 0; flush_req = 0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", {ex_ext_op, ex_alu_src, ex_alu_op, ex_reg_dst, mem_wr, mem_branch,
                     wb_mem_to_reg, wb_reg_wr}, 10'b0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule